// File: doc/BRIEF.md
# Pipelined 32-bit Integer Multiplier with Signedness Modes

This unit computes the product of two 32-bit register operands for an integer execution pipeline. A two-bit selector picks one of four results: the low word of the product, or the high word of the 64-bit product with both operands signed, with the first signed and the second unsigned, or with both unsigned. No operand pair is illegal, and the unit has no error or exception output.

Each operand is first widened to 33 bits, with either a copy of its top bit or a zero, according to the selected operation. One signed 33 x 33 datapath then serves all four cases. That datapath splits each widened operand into a low and a high slice and forms four partial products in the first pipeline stage. The second stage adds the partial products and selects the requested word.

Requests enter through a valid/ready port and results leave through another. A request transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. Once `out_valid` is raised, it stays high and `out_data` holds steady until the result is taken. Back-pressure moves stage by stage: an empty stage accepts new data even while the output is stalled. With `out_ready` held high, the unit accepts one request every cycle.

Top module: `imul_unit`

## Requirements
- R1: With `in_op` = 2'b00, the result is bits 31:0 of the product of `in_a` and `in_b`.
- R2: With `in_op` = 2'b01, both operands are read as two's-complement values, and the result is bits 63:32 of their 64-bit product.
- R3: With `in_op` = 2'b10, `in_a` is read as two's-complement and `in_b` as unsigned, and the result is bits 63:32 of their product.
- R4: With `in_op` = 2'b11, both operands are read as unsigned, and the result is bits 63:32 of their product.
- R5: Sign-boundary operands give the exact mathematical results in every mode. 0x80000000 x 0x80000000 gives low 0x00000000, signed high 0x40000000, mixed high 0xC0000000 and unsigned high 0x40000000. 0xFFFFFFFF x 0xFFFFFFFF gives low 0x00000001, signed high 0x00000000, mixed high 0xFFFFFFFF and unsigned high 0xFFFFFFFE. A zero operand gives 0 in all modes.
- R6: If a request is accepted in cycle c and `out_ready` is high in cycle c+1, then `out_valid` is high with that request's result in cycle c+2.
- R7: Whenever `out_ready` is high, `in_ready` is high, so a new request can be accepted every cycle.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_data` unchanged.
- R9: A synchronous active-high `rst` clears both pipeline stages: `out_valid` is low in the cycle after any edge at which `rst` is high, and results in flight are discarded.
- R10: Every accepted request produces exactly one result, and results leave in the order their requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 2 | Operation: 00 low, 01 signed high, 10 mixed high, 11 unsigned high |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Selected 32-bit word of the product |

## Verification
A result is due two cycles after its request is accepted, provided `out_ready` was high in the cycle in between. Under back-pressure it is due at the first later cycle in which the consumer takes it. The bench drives inputs on the falling edge, then looks one nanosecond later at which handshakes will complete on the coming rising edge. It queues each accepted request with its expected value and its cycle number, and pops the queue on each result transfer. In the full-speed phase it also requires that the pop cycle equals the accept cycle plus two. Stall windows are checked cycle to cycle for a held `out_data`.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [1:0] {
    OP_LOW   = 2'b00,
    OP_HI_SS = 2'b01,
    OP_HI_SU = 2'b10,
    OP_HI_UU = 2'b11
  } imul_op_e;

  // First operand is widened with its sign unless both are unsigned.
  function automatic logic op_a_signed(input imul_op_e op);
    return op != OP_HI_UU;
  endfunction

  // Second operand is widened with its sign for the low and signed-high forms.
  function automatic logic op_b_signed(input imul_op_e op);
    return (op == OP_LOW) || (op == OP_HI_SS);
  endfunction

  function automatic logic op_wants_high(input imul_op_e op);
    return op != OP_LOW;
  endfunction

endpackage

// File: rtl/imul_operand_ext.sv
module imul_operand_ext #(
  parameter int W = 32
) (
  input  logic [W-1:0]      raw,
  input  logic              as_signed,
  output logic signed [W:0] ext
);
  logic top_bit;

  always_comb begin
    top_bit = as_signed & raw[W-1];
    ext     = $signed({top_bit, raw});
  end
endmodule

// File: rtl/imul_partials.sv
module imul_partials #(
  parameter int W = 32
) (
  input  logic signed [W:0]          ext_a,
  input  logic signed [W:0]          ext_b,
  output logic [3:0][2*(W+1)-1:0]    pp
);
  localparam int EW     = W + 1;
  localparam int PW     = 2 * EW;
  localparam int LO_W   = W / 2;
  localparam int HI_W   = EW - LO_W;
  localparam int PART_W = (HI_W > LO_W + 1) ? HI_W : LO_W + 1;
  localparam int RAW_W  = 2 * PART_W;

  logic signed [PART_W-1:0] a_part [2];
  logic signed [PART_W-1:0] b_part [2];

  // Low slices are unsigned magnitudes; high slices carry the sign.
  always_comb begin
    a_part[0] = PART_W'($signed({1'b0, ext_a[LO_W-1:0]}));
    a_part[1] = PART_W'($signed(ext_a[EW-1:LO_W]));
    b_part[0] = PART_W'($signed({1'b0, ext_b[LO_W-1:0]}));
    b_part[1] = PART_W'($signed(ext_b[EW-1:LO_W]));
  end

  for (genvar i = 0; i < 2; i++) begin : g_row
    for (genvar j = 0; j < 2; j++) begin : g_col
      logic signed [RAW_W-1:0] raw_prod;
      logic signed [PW-1:0]    wide_prod;
      always_comb begin
        raw_prod     = a_part[i] * b_part[j];
        wide_prod    = PW'(raw_prod);
        pp[i*2 + j]  = wide_prod <<< (LO_W * (i + j));
      end
    end
  end
endmodule

// File: rtl/imul_reduce.sv
module imul_reduce
  import imul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0][2*(W+1)-1:0] pp,
  input  imul_op_e                op,
  output logic [W-1:0]            word
);
  localparam int PW = 2 * (W + 1);

  logic [PW-1:0] lvl1 [2];
  logic [PW-1:0] total;

  // Two-level adder tree over the shifted partial products.
  for (genvar k = 0; k < 2; k++) begin : g_pair
    always_comb lvl1[k] = pp[2*k] + pp[2*k + 1];
  end

  always_comb begin
    total = lvl1[0] + lvl1[1];
    if (op_wants_high(op)) word = total[2*W-1:W];
    else                   word = total[W-1:0];
  end
endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);
  localparam int EW = XLEN + 1;
  localparam int PW = 2 * EW;

  imul_op_e         op_in;
  logic signed [XLEN:0] ext_a, ext_b;
  logic [3:0][PW-1:0]   pp_comb;

  logic               s1_valid;
  imul_op_e           s1_op;
  logic [3:0][PW-1:0] s1_pp;
  logic               s1_ready, s2_ready;
  logic [XLEN-1:0]    word_comb;

  always_comb op_in = imul_op_e'(in_op);

  imul_operand_ext #(.W(XLEN)) u_ext_a (
    .raw(in_a), .as_signed(op_a_signed(op_in)), .ext(ext_a)
  );
  imul_operand_ext #(.W(XLEN)) u_ext_b (
    .raw(in_b), .as_signed(op_b_signed(op_in)), .ext(ext_b)
  );

  imul_partials #(.W(XLEN)) u_pp (
    .ext_a(ext_a), .ext_b(ext_b), .pp(pp_comb)
  );

  // Stage readiness, from the output back towards the input.
  always_comb begin
    s2_ready = !out_valid || out_ready;
    s1_ready = !s1_valid || s2_ready;
    in_ready = s1_ready;
  end

  // Stage 1: partial products and operation.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (s1_ready) begin
      s1_valid <= in_valid;
    end
    if (!rst && s1_ready && in_valid) begin
      s1_op <= op_in;
      s1_pp <= pp_comb;
    end
  end

  imul_reduce #(.W(XLEN)) u_red (
    .pp(s1_pp), .op(s1_op), .word(word_comb)
  );

  // Stage 2: summed and selected word, presented at the output.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (s2_ready) begin
      out_valid <= s1_valid;
    end
    if (!rst && s2_ready && s1_valid) begin
      out_data <= word_comb;
    end
  end

  // History used only by the latency assertion.
  logic acc_q, acc_qq, ordy_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 1'b0;
      acc_qq <= 1'b0;
      ordy_q <= 1'b0;
    end else begin
      acc_q  <= in_valid && in_ready;
      acc_qq <= acc_q;
      ordy_q <= out_ready;
    end
  end

  // R6
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    acc_qq && ordy_q |-> out_valid);

  // R7
  accept_when_drained_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  stage1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    s1_valid && !s2_ready |=> s1_valid && $stable(s1_op) && $stable(s1_pp));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !s1_valid);

endmodule

// File: tb/sim_imul_unit.sv
module sim_imul_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  imul_unit #(.XLEN(32)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int cycle    = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  int          cyc_q[$];
  bit          tim_q[$];
  string       tag_q[$];

  bit          timed_phase = 1'b0;
  bit          hold_pend   = 1'b0;
  logic [31:0] hold_data;

  function automatic logic [31:0] ref_mul(input logic [1:0] op,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb, p;
    bit sa, sb;
    sa = (op != 2'b11);
    sb = (op == 2'b00) || (op == 2'b01);
    ea = sa ? {{32{a[31]}}, a} : {32'd0, a};
    eb = sb ? {{32{b[31]}}, b} : {32'd0, b};
    p  = ea * eb;
    return (op == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // Called 1 ns after each falling edge: scores the transfers of the coming edge.
  task automatic observe();
    if (hold_pend)
      check(out_valid && out_data == hold_data, "R8", out_data, hold_data);
    hold_pend = out_valid && !out_ready;
    hold_data = out_data;
    if (out_ready) check(in_ready, "R7", {31'd0, in_ready}, 32'd1);
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_mul(in_op, in_a, in_b));
      cyc_q.push_back(cycle);
      tim_q.push_back(timed_phase);
      tag_q.push_back(op_tag(in_op));
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 extra result", out_data, 32'd0);
      end else begin
        logic [31:0] e;
        int c;
        bit t;
        string g;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tim_q.pop_front();
        g = tag_q.pop_front();
        check(out_data == e, {"R10 ", g}, out_data, e);
        if (t) check(cycle == c + 2, "R6", cycle, c + 2);
      end
    end
  endtask

  // Presents one request and holds it until accepted.
  task automatic send(input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input bit rand_ready);
    bit taken = 1'b0;
    while (!taken) begin
      @(negedge clk);
      cycle++;
      in_valid  = 1'b1;
      in_op     = op;
      in_a      = a;
      in_b      = b;
      out_ready = rand_ready ? ($urandom % 10 < 6) : 1'b1;
      #1;
      taken = in_ready;
      observe();
    end
  endtask

  task automatic idle(input int n, input bit rand_ready);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycle++;
      in_valid  = 1'b0;
      out_ready = rand_ready ? ($urandom % 10 < 6) : 1'b1;
      #1;
      observe();
    end
  endtask

  task automatic corner(input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] known);
    // R5: hand-derived expectation cross-checked against the reference model
    check(ref_mul(op, a, b) == known, "R5 model", ref_mul(op, a, b), known);
    send(op, a, b, 1'b0);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] c [5];
    c[0] = 32'h8000_0000; c[1] = 32'hFFFF_FFFF; c[2] = 32'h0;
    c[3] = 32'h7FFF_FFFF; c[4] = 32'h0000_0001;
    return ($urandom % 4 == 0) ? c[$urandom % 5] : $urandom;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R9 reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;

    // R5 directed corners, full speed so R6 timing is checked too
    timed_phase = 1'b1;
    corner(2'b00, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000);
    corner(2'b01, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000);
    corner(2'b10, 32'h8000_0000, 32'h8000_0000, 32'hC000_0000);
    corner(2'b11, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000);
    corner(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001);
    corner(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000);
    corner(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    corner(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
    for (int op = 0; op < 4; op++) begin
      corner(op[1:0], 32'h0, 32'hFFFF_FFFF, 32'h0);
      corner(op[1:0], 32'h8000_0000, 32'h0, 32'h0);
    end
    for (int i = 0; i < 200; i++) send(2'($urandom), pick(), pick(), 1'b0);
    idle(4, 1'b0);
    timed_phase = 1'b0;

    // Random operands with random gaps and back-pressure (R1-R4, R8, R10)
    for (int i = 0; i < 3000; i++) begin
      send(2'($urandom), pick(), pick(), 1'b1);
      if ($urandom % 4 == 0) idle(1 + $urandom % 3, 1'b1);
    end
    idle(8, 1'b0);
    check(exp_q.size() == 0, "R10 drained", exp_q.size(), 32'd0);

    // R9: reset with results in flight discards them
    out_ready = 1'b0;
    send(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
    @(negedge clk);
    cycle++;
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    cycle++;
    #1;
    check(!out_valid, "R9 flush", {31'd0, out_valid}, 32'd0);
    exp_q.delete(); cyc_q.delete(); tim_q.delete(); tag_q.delete();
    hold_pend = 1'b0;
    rst = 1'b0;
    out_ready = 1'b1;
    idle(4, 1'b0);
    check(!out_valid, "R9 after", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule